// File: doc/BRIEF.md
# Control-Flow and Load-Relative Decoder

This block is the combinational control decoder of a single-cycle processor for the instructions that change the program counter or use it as an address. It takes the 6-bit opcode of the current instruction and the zero flag, which reports that the first source register reads as all zeros. From these it drives the datapath selects: the source of the next program counter, the source of the register write-back data, the register-file write strobe, the memory write strobe, the ALU operand-A select and the ALU function code.

Unconditional jumps take the register value as the next PC. Conditional branches pick between the branch target and the incremented PC from the zero flag. Both write the return address into the destination register. The load-relative instruction reuses the branch-offset adder as the memory address. That address reaches memory through the operand-A select and an ALU pass-through of operand A, so plain loads and stores share one address path with it. Every control output has a fixed default when it does not matter to an instruction. The memory write strobe is defined for every opcode. Any opcode not listed here is flagged as illegal and made harmless.

Top module: `flow_ctl_decoder`

## Requirements
- R1: Opcode 6'h1B (jump) drives next-PC select 2 (register value), write-back select 0 (PC+4), register write 1 and memory write 0.
- R2: Opcode 6'h1C (branch if zero) drives next-PC select 1 (branch target) when the zero flag is 1 and 0 (PC+4) when it is 0, with write-back select 0 and register write 1 in both cases.
- R3: Opcode 6'h1D (branch if not zero) drives next-PC select 1 when the zero flag is 0 and 0 when it is 1, with write-back select 0 and register write 1.
- R4: Opcode 6'h1F (load-relative) drives operand-A select 1 (offset adder), ALU function 6'h1A (pass operand A), write-back select 2 (memory data), register write 1, memory write 0 and next-PC select 0.
- R5: Opcode 6'h18 (load) drives operand-A select 0 (register value), ALU function 6'h00 (add), write-back select 2, register write 1, memory write 0 and next-PC select 0.
- R6: Opcode 6'h19 (store) drives memory write 1, register write 0, next-PC select 0, operand-A select 0 and ALU function 6'h00.
- R7: The memory write strobe is a defined 0 for every opcode other than 6'h19.
- R8: The zero flag has no effect on any output for opcodes other than 6'h1C and 6'h1D.
- R9: Any opcode outside the six above raises the illegal output and drives register write 0, memory write 0 and next-PC select 0. The illegal output is 0 for the six listed opcodes.
- R10: Outputs an instruction does not use take fixed defaults: operand-A select 0 and ALU function 6'h00 for every opcode except 6'h1F, and write-back select 0 for the store and for illegal opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Opcode of the current instruction |
| zero_i | input | 1 | High when the first source register is all zeros |
| pc_sel_o | output | 3 | Next-PC source: 0 PC+4, 1 branch target, 2 register value |
| wb_sel_o | output | 2 | Write-back source: 0 PC+4, 1 ALU result, 2 memory data |
| rf_we_o | output | 1 | Register-file write enable |
| mem_we_o | output | 1 | Memory write enable |
| opa_sel_o | output | 1 | ALU operand A: 0 register value, 1 offset adder |
| alu_fn_o | output | 6 | ALU function code |
| bad_op_o | output | 1 | Opcode not recognized |

## Verification
The assertions check every settled input combination. They cover the jump and both branch directions, the load-relative routing, the rule that only the store writes memory, the safe state for illegal opcodes and the operand-A and ALU defaults. The bench's scenarios are needed for the full output vector of each opcode. They sweep all 64 opcodes under both zero-flag values, which shows that the flag leaves non-branch outputs unchanged and that every unlisted code is caught. They also show that the plain load keeps its register-based address while the load-relative instruction switches to the offset adder.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;

  localparam int OP_W    = 6;
  localparam int PCSEL_W = 3;
  localparam int WBSEL_W = 2;
  localparam int FN_W    = 6;

  // number of recognized instruction classes and their hit-vector slots
  localparam int N_CLS  = 6;
  localparam int IX_LD  = 0;
  localparam int IX_ST  = 1;
  localparam int IX_JMP = 2;
  localparam int IX_BEQ = 3;
  localparam int IX_BNE = 4;
  localparam int IX_LDR = 5;

  localparam logic [OP_W-1:0] OPC_LD  = 6'h18;
  localparam logic [OP_W-1:0] OPC_ST  = 6'h19;
  localparam logic [OP_W-1:0] OPC_JMP = 6'h1B;
  localparam logic [OP_W-1:0] OPC_BEQ = 6'h1C;
  localparam logic [OP_W-1:0] OPC_BNE = 6'h1D;
  localparam logic [OP_W-1:0] OPC_LDR = 6'h1F;

  localparam logic [PCSEL_W-1:0] PC_INC    = 3'd0;
  localparam logic [PCSEL_W-1:0] PC_TARGET = 3'd1;
  localparam logic [PCSEL_W-1:0] PC_REG    = 3'd2;

  localparam logic [WBSEL_W-1:0] WB_LINK = 2'd0;
  localparam logic [WBSEL_W-1:0] WB_ALU  = 2'd1;
  localparam logic [WBSEL_W-1:0] WB_MEM  = 2'd2;

  localparam logic [FN_W-1:0] FN_ADD    = 6'h00;
  localparam logic [FN_W-1:0] FN_PASS_A = 6'h1A;

  typedef struct packed {
    logic [PCSEL_W-1:0] pc_sel;
    logic [WBSEL_W-1:0] wb_sel;
    logic               rf_we;
    logic               mem_we;
    logic               opa_sel;
    logic [FN_W-1:0]    alu_fn;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{pc_sel: PC_INC, wb_sel: WB_LINK, rf_we: 1'b0,
                                mem_we: 1'b0, opa_sel: 1'b0, alu_fn: FN_ADD};

endpackage

// File: rtl/flow_op_classify.sv
module flow_op_classify #(
  parameter int                  OP_W  = 6,
  parameter int                  N     = 6,
  parameter logic [N*OP_W-1:0]   CODES = '0
) (
  input  logic [OP_W-1:0] op_i,
  output logic [N-1:0]    hit_o,
  output logic            bad_o
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_match
      assign hit_o[g] = (op_i == CODES[g*OP_W +: OP_W]);
    end
  endgenerate

  assign bad_o = ~|hit_o;

endmodule

// File: rtl/flow_branch_resolve.sv
module flow_branch_resolve (
  input  logic is_beq_i,
  input  logic is_bne_i,
  input  logic zero_i,
  output logic take_o
);

  logic eq_take;
  logic ne_take;

  assign eq_take = is_beq_i &  zero_i;
  assign ne_take = is_bne_i & ~zero_i;
  assign take_o  = eq_take | ne_take;

endmodule

// File: rtl/flow_ctl_encode.sv
module flow_ctl_encode
  import flow_ctl_pkg::*;
#(
  parameter int N = N_CLS
) (
  input  logic [N-1:0] hit_i,
  input  logic         take_i,
  output ctl_t         ctl_o
);

  always_comb begin
    ctl_o = CTL_IDLE;
    if (hit_i[IX_JMP]) begin
      ctl_o.pc_sel = PC_REG;
      ctl_o.wb_sel = WB_LINK;
      ctl_o.rf_we  = 1'b1;
    end else if (hit_i[IX_BEQ] || hit_i[IX_BNE]) begin
      ctl_o.pc_sel = take_i ? PC_TARGET : PC_INC;
      ctl_o.wb_sel = WB_LINK;
      ctl_o.rf_we  = 1'b1;
    end else if (hit_i[IX_LDR]) begin
      ctl_o.opa_sel = 1'b1;
      ctl_o.alu_fn  = FN_PASS_A;
      ctl_o.wb_sel  = WB_MEM;
      ctl_o.rf_we   = 1'b1;
    end else if (hit_i[IX_LD]) begin
      ctl_o.alu_fn = FN_ADD;
      ctl_o.wb_sel = WB_MEM;
      ctl_o.rf_we  = 1'b1;
    end else if (hit_i[IX_ST]) begin
      ctl_o.alu_fn = FN_ADD;
      ctl_o.mem_we = 1'b1;
    end
  end

endmodule

// File: rtl/flow_ctl_decoder.sv
module flow_ctl_decoder
  import flow_ctl_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic       zero_i,
  output logic [2:0] pc_sel_o,
  output logic [1:0] wb_sel_o,
  output logic       rf_we_o,
  output logic       mem_we_o,
  output logic       opa_sel_o,
  output logic [5:0] alu_fn_o,
  output logic       bad_op_o
);

  localparam logic [N_CLS*OP_W-1:0] CODE_TABLE =
    {OPC_LDR, OPC_BNE, OPC_BEQ, OPC_JMP, OPC_ST, OPC_LD};

  logic [N_CLS-1:0] hit;
  logic             bad;
  logic             take;
  ctl_t             ctl;

  flow_op_classify #(
    .OP_W  (OP_W),
    .N     (N_CLS),
    .CODES (CODE_TABLE)
  ) u_classify (
    .op_i  (op_i),
    .hit_o (hit),
    .bad_o (bad)
  );

  flow_branch_resolve u_branch (
    .is_beq_i (hit[IX_BEQ]),
    .is_bne_i (hit[IX_BNE]),
    .zero_i   (zero_i),
    .take_o   (take)
  );

  flow_ctl_encode #(
    .N (N_CLS)
  ) u_encode (
    .hit_i  (hit),
    .take_i (take),
    .ctl_o  (ctl)
  );

  assign pc_sel_o  = ctl.pc_sel;
  assign wb_sel_o  = ctl.wb_sel;
  assign rf_we_o   = ctl.rf_we;
  assign mem_we_o  = ctl.mem_we;
  assign opa_sel_o = ctl.opa_sel;
  assign alu_fn_o  = ctl.alu_fn;
  assign bad_op_o  = bad;

endmodule

// File: rtl/flow_ctl_decoder_chk.sv
module flow_ctl_decoder_chk
  import flow_ctl_pkg::*;
(
  input logic [5:0] op_i,
  input logic       zero_i,
  input logic [2:0] pc_sel_o,
  input logic [1:0] wb_sel_o,
  input logic       rf_we_o,
  input logic       mem_we_o,
  input logic       opa_sel_o,
  input logic [5:0] alu_fn_o,
  input logic       bad_op_o
);

  always_comb begin
    if (!$isunknown({op_i, zero_i})) begin
      if (op_i == OPC_JMP) begin
        p_jmp_reg_target_r1: assert (pc_sel_o == 3'd2 && wb_sel_o == 2'd0 && rf_we_o)
          else $error("R1 jump controls wrong");
      end
      if (op_i == OPC_BEQ) begin
        p_beq_direction_r2: assert (pc_sel_o == (zero_i ? 3'd1 : 3'd0) && rf_we_o)
          else $error("R2 branch-if-zero direction wrong");
      end
      if (op_i == OPC_BNE) begin
        p_bne_direction_r3: assert (pc_sel_o == (zero_i ? 3'd0 : 3'd1) && rf_we_o)
          else $error("R3 branch-if-not-zero direction wrong");
      end
      if (op_i == OPC_LDR) begin
        p_ldr_route_r4: assert (opa_sel_o && alu_fn_o == 6'h1A && wb_sel_o == 2'd2 && rf_we_o)
          else $error("R4 load-relative routing wrong");
      end
      p_store_only_writes_r7: assert (mem_we_o === (op_i == OPC_ST))
        else $error("R7 memory write strobe wrong");
      if (bad_op_o) begin
        p_illegal_safe_r9: assert (!rf_we_o && !mem_we_o && pc_sel_o == 3'd0)
          else $error("R9 illegal opcode not made safe");
      end
      if (op_i != OPC_LDR) begin
        p_opa_default_r10: assert (!opa_sel_o && alu_fn_o == 6'h00)
          else $error("R10 operand-A default wrong");
      end
    end
  end

endmodule

bind flow_ctl_decoder flow_ctl_decoder_chk u_chk (
  .op_i      (op_i),
  .zero_i    (zero_i),
  .pc_sel_o  (pc_sel_o),
  .wb_sel_o  (wb_sel_o),
  .rf_we_o   (rf_we_o),
  .mem_we_o  (mem_we_o),
  .opa_sel_o (opa_sel_o),
  .alu_fn_o  (alu_fn_o),
  .bad_op_o  (bad_op_o)
);

// File: tb/flow_ctl_decoder_test.sv
`timescale 1ns/1ps
module flow_ctl_decoder_test;

  logic       clk;
  logic       rst_n;
  logic [5:0] op;
  logic       zero;
  logic [2:0] pc_sel;
  logic [1:0] wb_sel;
  logic       rf_we;
  logic       mem_we;
  logic       opa_sel;
  logic [5:0] alu_fn;
  logic       bad_op;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // packed view: pc(3) wb(2) rfwe mwe opa fn(6) bad = 15 bits
  typedef struct {
    logic [14:0] exp;
    logic [5:0]  op;
    logic        zero;
    string       tag;
  } item_t;

  item_t sb[$];

  flow_ctl_decoder uut (
    .op_i      (op),
    .zero_i    (zero),
    .pc_sel_o  (pc_sel),
    .wb_sel_o  (wb_sel),
    .rf_we_o   (rf_we),
    .mem_we_o  (mem_we),
    .opa_sel_o (opa_sel),
    .alu_fn_o  (alu_fn),
    .bad_op_o  (bad_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected outputs taken from the requirement list
  function automatic logic [14:0] model(input logic [5:0] o, input logic z);
    logic [2:0] p; logic [1:0] w; logic we, mw, a, b; logic [5:0] f;
    p = 3'd0; w = 2'd0; we = 1'b0; mw = 1'b0; a = 1'b0; f = 6'h00; b = 1'b0;
    case (o)
      6'h1B: begin p = 3'd2; we = 1'b1; end                     // R1
      6'h1C: begin p = z ? 3'd1 : 3'd0; we = 1'b1; end           // R2
      6'h1D: begin p = z ? 3'd0 : 3'd1; we = 1'b1; end           // R3
      6'h1F: begin a = 1'b1; f = 6'h1A; w = 2'd2; we = 1'b1; end // R4
      6'h18: begin w = 2'd2; we = 1'b1; end                      // R5
      6'h19: begin mw = 1'b1; end                                // R6
      default: b = 1'b1;                                         // R9
    endcase
    return {p, w, we, mw, a, f, b};
  endfunction

  function automatic string tag_of(input logic [5:0] o, input logic z);
    case (o)
      6'h1B:   return z ? "R1,R8" : "R1";
      6'h1C:   return "R2";
      6'h1D:   return "R3";
      6'h1F:   return z ? "R4,R8" : "R4";
      6'h18:   return z ? "R5,R8" : "R5";
      6'h19:   return z ? "R6,R7,R10" : "R6,R10";
      default: return z ? "R9,R7,R8" : "R9,R10";
    endcase
  endfunction

  task automatic drive(input logic [5:0] o, input logic z);
    item_t it;
    @(posedge clk);
    op   <= o;
    zero <= z;
    it.exp  = model(o, z);
    it.op   = o;
    it.zero = z;
    it.tag  = tag_of(o, z);
    sb.push_back(it);
  endtask

  // monitor: compare at the falling edge, after inputs settle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [14:0] act;
      it  = sb.pop_front();
      act = {pc_sel, wb_sel, rf_we, mem_we, opa_sel, alu_fn, bad_op};
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s op=%h zero=%0d actual=%h expected=%h",
                 it.tag, it.op, it.zero, act, it.exp);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    op    = 6'h00;
    zero  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: opcode 0 is unlisted, so outputs sit in the safe state (R9)
    n_checks++;
    if ({pc_sel, rf_we, mem_we, bad_op} !== {3'd0, 1'b0, 1'b0, 1'b1}) begin
      n_fail++;
      $display("FAIL R9 reset state actual=%h expected=%h",
               {pc_sel, rf_we, mem_we, bad_op}, {3'd0, 1'b0, 1'b0, 1'b1});
    end
    rst_n = 1'b1;

    // directed: branch directions both ways, jump, load pair
    drive(6'h1C, 1'b1); drive(6'h1C, 1'b0);
    drive(6'h1D, 1'b1); drive(6'h1D, 1'b0);
    drive(6'h1B, 1'b0); drive(6'h1F, 1'b1);
    drive(6'h18, 1'b0); drive(6'h19, 1'b1);
    // neighbours of listed codes
    drive(6'h1A, 1'b0); drive(6'h1E, 1'b1); drive(6'h17, 1'b0); drive(6'h3F, 1'b1);

    // full sweep, both flag values (R7, R8, R9, R10)
    for (int i = 0; i < 64; i++) begin
      drive(6'(i), 1'b0);
      drive(6'(i), 1'b1);
    end
    // flag toggled while opcode held (R8)
    drive(6'h1F, 1'b0); drive(6'h1F, 1'b1); drive(6'h19, 1'b0); drive(6'h19, 1'b1);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule